// File: doc/BRIEF.md
# Channel Status Block Sequencer

This block supplies the channel status bit carried by every subframe of a serial digital audio transmitter. It keeps a position counter inside the channel status block and produces one channel status bit per subframe. A block is 192 frames, so it holds 384 subframes. Left and right subframes of one frame share one bit index. The transmitter pulses a one-clock subframe strobe at the start of each subframe. On that strobe the block registers the bit for the new subframe, together with a flag that is high while that subframe is the first one of a block.

Two sources feed the bit stream. In pin mode, the bit stream is built from three static inputs: copy permission, originality and an active-low pre-emphasis request. In direct mode, the copy pin becomes a serial bit input, and its level at each strobe is passed through unchanged.

The block-start signal is bidirectional and is split into an input, an output and an output enable. A direction input selects one of two uses:
- The block announces its own block starts on the output.
- An external high level, seen on at least a parameterised number of consecutive clocks, forces the next subframe to open a new block. This is how several transmitters are kept in step.

Top module: `csb_sequencer`

## Requirements
- R1: While `rst_ni` is low, `cbit_o` and `blk_start_o` are 0. The first strobe after reset opens a block, so subframe index 0 is emitted with `blk_start_o` high.
- R2: `blk_start_o` is 1 only for subframe index 0 of a block and 0 for the others. Without a forced start the index runs 0 to 383 and then wraps to 0.
- R3: `cbit_o` and `blk_start_o` take new values only in the clock after a cycle in which `sub_stb_i` is high. Otherwise they hold their values.
- R4: In pin mode (`direct_mode_i` = 0), channel status bit 2 equals `copy_c_i`.
- R5: In pin mode, `emph_ni` = 0 gives bit 3 = 1, bit 4 = 0 and bit 5 = 0. Read from bit 5 down to bit 3, this is code 001, meaning 50/15 us. `emph_ni` = 1 gives all three bits 0.
- R6: In pin mode, bit 15 equals `orig_i`. Bit 0 (professional flag) is 0, and every other bit is 0.
- R7: The bit index of a subframe is its subframe index divided by two. Both subframes of a frame carry the same bit.
- R8: In direct mode (`direct_mode_i` = 1), `cbit_o` after a strobe equals `copy_c_i` sampled on that strobe.
- R9: With `blk_dir_i` = 0, a high on `blk_start_i` sampled on 3 or more consecutive clock edges makes the next strobed subframe index 0. A long hold forces only once.
- R10: With `blk_dir_i` = 0, a high on `blk_start_i` lasting 1 or 2 clock edges has no effect on the position.
- R11: With `blk_dir_i` = 1, `blk_start_i` has no effect, and `blk_start_oe_o` is 1. With `blk_dir_i` = 0, `blk_start_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Active-low reset |
| sub_stb_i | input | 1 | One-clock pulse at the start of each subframe |
| direct_mode_i | input | 1 | 0 = pin mode, 1 = direct serial bit mode |
| copy_c_i | input | 1 | Copy permission (pin mode) or serial channel status bit (direct mode) |
| orig_i | input | 1 | Originality, sent in bit 15 in pin mode |
| emph_ni | input | 1 | Active-low 50/15 us pre-emphasis request |
| blk_dir_i | input | 1 | 1 = block start is driven out, 0 = block start is sampled in |
| blk_start_i | input | 1 | External block-start level |
| cbit_o | output | 1 | Channel status bit of the current subframe |
| blk_start_o | output | 1 | High during the first subframe of a block |
| blk_start_oe_o | output | 1 | Output enable for the block-start pad |

## Verification
Pin mode is tried with two opposite settings of copy, originality and emphasis over more than one full block. This shows whether each bit position is mapped correctly, whether the emphasis code is inverted or misplaced, and whether the wrap happens at 384. Direct mode is driven with an irregular serial pattern, so that a stale sample or a per-frame sample cannot go unnoticed. External block-start pulses of 2, 3 and 5 clocks are given in input direction, and a 5-clock pulse in output direction. Together these separate the qualification threshold, the single force per hold, and the direction gating. A reset in the middle of a block checks that the position is cleared.

// File: rtl/csb_pkg.sv
`timescale 1ns/1ps
package csb_pkg;
   // channel status bit positions used in pin mode
   localparam int unsigned CS_PRO_BIT  = 0;
   localparam int unsigned CS_COPY_BIT = 2;
   localparam int unsigned CS_EMPH_LSB = 3;
   localparam int unsigned CS_GEN_BIT  = 15;
   // emphasis code, element 0 lands on CS_EMPH_LSB
   localparam logic [2:0]  CS_EMPH_5015 = 3'b001;

   typedef struct packed {
      logic copy;
      logic orig;
      logic emph_n;
   } csb_pins_t;

   function automatic logic csb_pin_bit(input int unsigned k, input csb_pins_t p);
      logic b;
      case (k)
         CS_PRO_BIT:      b = 1'b0;
         CS_COPY_BIT:     b = p.copy;
         CS_EMPH_LSB:     b = ~p.emph_n & CS_EMPH_5015[0];
         CS_EMPH_LSB + 1: b = ~p.emph_n & CS_EMPH_5015[1];
         CS_EMPH_LSB + 2: b = ~p.emph_n & CS_EMPH_5015[2];
         CS_GEN_BIT:      b = p.orig;
         default:         b = 1'b0;
      endcase
      return b;
   endfunction
endpackage

// File: rtl/csb_qualifier.sv
`timescale 1ns/1ps
module csb_qualifier #(
   parameter int unsigned QUAL_CLKS = 3
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_i,
   input  logic level_i,
   input  logic stb_i,
   output logic force_o
);
   logic hit;
   logic pend_q;

   generate
      if (QUAL_CLKS == 1) begin : g_edge
         logic prev_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) prev_q <= 1'b0;
            else         prev_q <= en_i & level_i;
         end
         assign hit = en_i & level_i & ~prev_q;
      end else begin : g_count
         localparam int unsigned CW = $clog2(QUAL_CLKS + 1);
         localparam logic [CW-1:0] RUN_MAX = CW'(QUAL_CLKS);
         localparam logic [CW-1:0] RUN_ARM = CW'(QUAL_CLKS - 1);
         logic [CW-1:0] run_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)                 run_q <= '0;
            else if (!(en_i && level_i)) run_q <= '0;
            else if (run_q != RUN_MAX)   run_q <= run_q + 1'b1;
         end
         assign hit = en_i & level_i & (run_q == RUN_ARM);
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    pend_q <= 1'b0;
      else if (stb_i) pend_q <= 1'b0;
      else if (hit)   pend_q <= 1'b1;
   end

   assign force_o = pend_q | hit;
endmodule

// File: rtl/csb_position.sv
`timescale 1ns/1ps
module csb_position #(
   parameter int unsigned FRAMES_PER_BLK = 192,
   localparam int unsigned SUBFRAMES = 2 * FRAMES_PER_BLK,
   localparam int unsigned SW = $clog2(SUBFRAMES)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          stb_i,
   input  logic          force_i,
   output logic [SW-1:0] next_idx_o
);
   localparam logic [SW-1:0] LAST = SW'(SUBFRAMES - 1);

   logic [SW-1:0] idx_q;
   logic          started_q;

   always_comb begin
      if (!started_q || force_i) next_idx_o = '0;
      else if (idx_q == LAST)    next_idx_o = '0;
      else                       next_idx_o = idx_q + 1'b1;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         idx_q     <= '0;
         started_q <= 1'b0;
      end else if (stb_i) begin
         idx_q     <= next_idx_o;
         started_q <= 1'b1;
      end
   end
endmodule

// File: rtl/csb_cbit_gen.sv
`timescale 1ns/1ps
module csb_cbit_gen
   import csb_pkg::*;
#(
   parameter int unsigned SW = 9
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          stb_i,
   input  logic          direct_i,
   input  csb_pins_t     pins_i,
   input  logic [SW-1:0] next_idx_i,
   output logic          cbit_o,
   output logic          first_o
);
   logic [SW-2:0] frame_idx;
   logic          pin_bit;

   assign frame_idx = next_idx_i[SW-1:1];
   assign pin_bit   = csb_pin_bit(int'(frame_idx), pins_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cbit_o  <= 1'b0;
         first_o <= 1'b0;
      end else if (stb_i) begin
         cbit_o  <= direct_i ? pins_i.copy : pin_bit;
         first_o <= (next_idx_i == '0);
      end
   end
endmodule

// File: rtl/csb_sequencer.sv
`timescale 1ns/1ps
module csb_sequencer
   import csb_pkg::*;
#(
   parameter int unsigned FRAMES_PER_BLK = 192,
   parameter int unsigned QUAL_CLKS      = 3
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic sub_stb_i,
   input  logic direct_mode_i,
   input  logic copy_c_i,
   input  logic orig_i,
   input  logic emph_ni,
   input  logic blk_dir_i,
   input  logic blk_start_i,
   output logic cbit_o,
   output logic blk_start_o,
   output logic blk_start_oe_o
);
   localparam int unsigned SW = $clog2(2 * FRAMES_PER_BLK);

   generate
      if (FRAMES_PER_BLK <= CS_GEN_BIT) begin : g_bad_frames
         $error("FRAMES_PER_BLK must exceed the highest pin-driven bit index");
      end
      if (QUAL_CLKS < 1) begin : g_bad_qual
         $error("QUAL_CLKS must be at least 1");
      end
   endgenerate

   logic          force_start;
   logic [SW-1:0] next_idx;
   csb_pins_t     pins;

   assign pins.copy   = copy_c_i;
   assign pins.orig   = orig_i;
   assign pins.emph_n = emph_ni;

   csb_qualifier #(.QUAL_CLKS(QUAL_CLKS)) u_qual (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (~blk_dir_i),
      .level_i (blk_start_i),
      .stb_i   (sub_stb_i),
      .force_o (force_start)
   );

   csb_position #(.FRAMES_PER_BLK(FRAMES_PER_BLK)) u_pos (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .stb_i      (sub_stb_i),
      .force_i    (force_start),
      .next_idx_o (next_idx)
   );

   csb_cbit_gen #(.SW(SW)) u_gen (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .stb_i      (sub_stb_i),
      .direct_i   (direct_mode_i),
      .pins_i     (pins),
      .next_idx_i (next_idx),
      .cbit_o     (cbit_o),
      .first_o    (blk_start_o)
   );

   assign blk_start_oe_o = blk_dir_i;
endmodule

// File: rtl/csb_sequencer_chk.sv
`timescale 1ns/1ps
module csb_sequencer_chk #(
   parameter int unsigned QUAL_CLKS = 3
) (
   input logic clk_i,
   input logic rst_ni,
   input logic sub_stb_i,
   input logic direct_mode_i,
   input logic copy_c_i,
   input logic blk_dir_i,
   input logic blk_start_i,
   input logic cbit_o,
   input logic blk_start_o
);
   localparam int unsigned CW = $clog2(QUAL_CLKS + 1);
   localparam logic [CW-1:0] RMAX = CW'(QUAL_CLKS);
   localparam logic [CW-1:0] RARM = CW'(QUAL_CLKS - 1);

   logic [CW-1:0] run_q;
   logic          armed_q;
   logic          qual_now;
   logic          chk_force;

   assign qual_now  = !blk_dir_i && blk_start_i && (run_q == RARM);
   assign chk_force = armed_q || qual_now;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q   <= '0;
         armed_q <= 1'b0;
      end else begin
         if (blk_dir_i || !blk_start_i) run_q <= '0;
         else if (run_q != RMAX)        run_q <= run_q + 1'b1;
         if (sub_stb_i)     armed_q <= 1'b0;
         else if (qual_now) armed_q <= 1'b1;
      end
   end

   p_reset_clear_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rst_ni) |-> (!cbit_o && !blk_start_o));

   p_hold_between_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(sub_stb_i) |-> ($stable(cbit_o) && $stable(blk_start_o)));

   p_pro_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(sub_stb_i) && !$past(direct_mode_i) && blk_start_o) |-> !cbit_o);

   p_direct_pass_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sub_stb_i && direct_mode_i) |=> (cbit_o == $past(copy_c_i)));

   p_forced_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sub_stb_i && chk_force) |=> blk_start_o);
endmodule

bind csb_sequencer csb_sequencer_chk #(.QUAL_CLKS(QUAL_CLKS)) u_chk (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .sub_stb_i     (sub_stb_i),
   .direct_mode_i (direct_mode_i),
   .copy_c_i      (copy_c_i),
   .blk_dir_i     (blk_dir_i),
   .blk_start_i   (blk_start_i),
   .cbit_o        (cbit_o),
   .blk_start_o   (blk_start_o)
);

// File: tb/tb_csb_sequencer.sv
`timescale 1ns/1ps
module tb_csb_sequencer;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sub_stb = 1'b0;
   logic direct_mode = 1'b0;
   logic copy_c = 1'b0;
   logic orig = 1'b0;
   logic emph_n = 1'b1;
   logic blk_dir = 1'b1;
   logic blk_start_in = 1'b0;
   logic cbit, blk_start, blk_oe;

   int n_chk = 0;
   int n_bad = 0;

   typedef struct {
      logic  c;
      logic  s;
      string tc;
      string ts;
   } exp_t;
   exp_t q[$];
   exp_t last;
   bit   have_last = 0;

   int m_idx = 0;
   bit m_started = 0;
   bit m_force = 0;

   always #2 clk = ~clk;

   csb_sequencer dut (
      .clk_i(clk), .rst_ni(rst_n), .sub_stb_i(sub_stb),
      .direct_mode_i(direct_mode), .copy_c_i(copy_c), .orig_i(orig),
      .emph_ni(emph_n), .blk_dir_i(blk_dir), .blk_start_i(blk_start_in),
      .cbit_o(cbit), .blk_start_o(blk_start), .blk_start_oe_o(blk_oe)
   );

   task automatic check(input logic act, input logic exp, input string req);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%b expected=%b (subframe %0d)", req, act, exp, m_idx);
      end
   endtask

   function automatic logic exp_pin(input int k, input logic cp, input logic og, input logic en);
      if (k == 2)  return cp;
      if (k == 3)  return !en;
      if (k == 15) return og;
      return 1'b0;
   endfunction

   function automatic string pin_tag(input int idx);
      int k = idx / 2;
      if (idx % 2 == 1) return "R7";
      if (k == 2) return "R4";
      if (k >= 3 && k <= 5) return "R5";
      return "R6";
   endfunction

   task automatic send_sf(input logic cin, input string tc, input string ts);
      exp_t e;
      @(negedge clk);
      copy_c = cin;
      if (!m_started || m_force) m_idx = 0;
      else m_idx = (m_idx == 383) ? 0 : m_idx + 1;
      m_started = 1;
      m_force = 0;
      e.c  = direct_mode ? cin : exp_pin(m_idx / 2, cin, orig, emph_n);
      e.s  = (m_idx == 0);
      e.tc = (tc == "") ? pin_tag(m_idx) : tc;
      e.ts = ts;
      q.push_back(e);
      sub_stb = 1'b1;
      @(negedge clk);
      sub_stb = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic pulse(input int n);
      @(negedge clk);
      blk_start_in = 1'b1;
      repeat (n) @(negedge clk);
      blk_start_in = 1'b0;
      if (!blk_dir && n >= 3) m_force = 1;
   endtask

   // monitor: compare after each strobe, check hold between strobes
   always @(posedge clk) begin
      if (rst_n) begin
         if (sub_stb) begin
            #1;
            if (q.size() == 0) begin
               n_chk++; n_bad++;
               $display("FAIL R3 actual=unexpected-strobe expected=queued-item");
            end else begin
               last = q.pop_front();
               have_last = 1;
               check(cbit, last.c, last.tc);
               check(blk_start, last.s, last.ts);
            end
         end else if (have_last) begin
            #1;
            if (have_last && rst_n) begin
               check(cbit, last.c, "R3");
               check(blk_start, last.s, "R3");
            end
         end
      end
   end

   initial begin
      #(4 * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(cbit, 1'b0, "R1");
      check(blk_start, 1'b0, "R1");
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // pin mode, pattern A: first subframe after reset opens block (R1)
      copy_c = 1; orig = 1; emph_n = 0; blk_dir = 1;
      send_sf(1'b1, "", "R1");
      for (int i = 1; i < 394; i++) send_sf(1'b1, "", "R2");
      check(blk_oe, 1'b1, "R11");

      // pattern B: opposite pin settings
      orig = 0; emph_n = 1;
      for (int i = 0; i < 40; i++) send_sf(1'b0, "", "R2");

      // direct mode with irregular serial bits
      direct_mode = 1;
      for (int i = 0; i < 24; i++) send_sf(logic'(((i * 7) % 5) < 2), "R8", "R2");
      direct_mode = 0;

      // input direction: short pulse ignored
      blk_dir = 0;
      @(negedge clk);
      check(blk_oe, 1'b0, "R11");
      pulse(2);
      for (int i = 0; i < 6; i++) send_sf(1'b1, "R10", "R10");
      pulse(1);
      for (int i = 0; i < 4; i++) send_sf(1'b1, "R10", "R10");
      // qualified pulses force a block start once
      pulse(3);
      for (int i = 0; i < 12; i++) send_sf(1'b1, "R9", "R9");
      pulse(5);
      for (int i = 0; i < 8; i++) send_sf(1'b1, "R9", "R9");

      // output direction: external level ignored
      blk_dir = 1;
      @(negedge clk);
      check(blk_oe, 1'b1, "R11");
      pulse(5);
      for (int i = 0; i < 8; i++) send_sf(1'b1, "R11", "R11");

      // reset in the middle of a block
      @(negedge clk);
      rst_n = 1'b0;
      have_last = 0;
      m_started = 0; m_idx = 0; m_force = 0;
      @(negedge clk);
      check(cbit, 1'b0, "R1");
      check(blk_start, 1'b0, "R1");
      rst_n = 1'b1;
      @(negedge clk);
      send_sf(1'b1, "", "R1");
      for (int i = 0; i < 8; i++) send_sf(1'b1, "", "R2");

      repeat (4) @(negedge clk);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule